// File: doc/BRIEF.md
# Video Pixel Word Packer

This block takes a 4:2:2 YUV pixel stream, one pixel per accepted cycle, with first-of-frame, last-of-line and last-of-frame markers. It packs the samples into 64-bit memory words in one of six packed layouts and hands them to a downstream memory writer as single-cycle beats, each with its own word address. Each pixel carries a luma sample and one chroma sample. Within a line, even pixels carry U and odd pixels carry V.

Software sets the layout and the base word address per frame through a descriptor, in two steps. A queue pulse loads the descriptor and leaves it unarmed. A separate post pulse then arms it. Capture starts only at a frame boundary. When the last word of the frame leaves the block, a sticky interrupt is raised, and it stays set until software clears it. Four layouts interleave luma and chroma sample by sample, in 8-bit or 16-bit form. Two layouts are 4:2:0 layouts that work in 16-pixel runs. Each run emits its luma first and then half of its chroma, with the chroma taken from the parity that matches the line.

Top module: `pix_pack_wr`

## Requirements
- R1: A `dsc_queue` pulse latches `dsc_mode` and `dsc_base` and leaves the descriptor unarmed. Only a later `dsc_post` pulse arms it. A queue pulse after a post disarms the descriptor until it is posted again. While no descriptor is armed, no beat is produced.
- R2: Capture starts on the pixel marked `pix_sof` that is accepted while a descriptor is armed and the block is idle. Starting capture consumes the arming. Pixels of a frame already under way when the post arrives produce no beats.
- R3: Mode 0 emits two bytes per pixel: the chroma low byte, then the luma low byte. Byte n of a frame's byte stream lands in `wr_data[8*(n%8)+7 : 8*(n%8)]` of the frame's word n/8. Codes 6 and 7 are reserved.
- R4: Mode 1 emits the luma low byte, then the chroma low byte, for each pixel.
- R5: Modes 2 and 3 follow the orders of modes 0 and 1 respectively, with full 16-bit samples. Each sample is stored low byte first.
- R6: Modes 4 (8-bit) and 5 (16-bit) are the 4:2:0 layouts. Each run of 16 pixels in a line gives its 16 luma samples, then 8 chroma samples. Even lines take the U samples of even pixels and odd lines take the V samples of odd pixels, counting the first line of the frame as line 0. The line width is a multiple of 16.
- R7: In 8-bit modes the upper 8 bits of `pix_y` and `pix_c` have no effect. In modes 4 and 5 the chroma of the other parity has no effect.
- R8: The byte stream continues across line ends with no gap. If the frame ends with a partial word, that word is zero-padded and emitted after the last-of-frame pixel.
- R9: A frame's first word carries the descriptor base address, and each further word carries the previous address plus one.
- R10: `irq` is low after reset. It rises in the same cycle as the frame's last beat and stays high until an `irq_clr` pulse. If completion and clear coincide, completion wins.
- R11: Cycles with `pix_valid` low change no output word and no parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsc_queue | input | 1 | Load descriptor fields, unarmed |
| dsc_mode | input | 3 | Layout code 0..5 |
| dsc_base | input | ADDR_W | First word address of the frame |
| dsc_post | input | 1 | Arm the loaded descriptor |
| irq_clr | input | 1 | Write-one clear of the interrupt |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_sof | input | 1 | First pixel of frame |
| pix_eol | input | 1 | Last pixel of line |
| pix_eof | input | 1 | Last pixel of frame |
| pix_y | input | 16 | Luma sample |
| pix_c | input | 16 | Chroma sample (U on even pixels, V on odd) |
| wr_valid | output | 1 | Word beat present |
| wr_data | output | 64 | Packed word |
| wr_addr | output | ADDR_W | Word address |
| irq | output | 1 | Frame-captured interrupt |

## Verification
The assertions assume that markers are well formed. A frame begins with a first-of-frame pixel and ends with exactly one last-of-frame pixel, and every line in the 4:2:0 modes is a multiple of 16 pixels. They also assume that a new frame does not start within two cycles of the previous one, so any chroma still queued has drained. The stimulus builds every frame from whole lines, uses only the widths 16 and 32 in modes 4 and 5, and leaves idle cycles between frames. The one frame that starts while a post is pending is driven with correct markers throughout. The address assertion assumes that the descriptor base is held while a frame is starting.

// File: rtl/pp_pkg.sv
package pp_pkg;

  typedef enum logic [2:0] {
    PK_CY8  = 3'd0,
    PK_YC8  = 3'd1,
    PK_CY16 = 3'd2,
    PK_YC16 = 3'd3,
    PK_MB8  = 3'd4,
    PK_MB16 = 3'd5
  } pk_mode_e;

  function automatic logic mode_is_mb(pk_mode_e m);
    return (m == PK_MB8) || (m == PK_MB16);
  endfunction

  function automatic logic mode_is_wide(pk_mode_e m);
    return (m == PK_CY16) || (m == PK_YC16) || (m == PK_MB16);
  endfunction

endpackage

// File: rtl/pp_lane.sv
module pp_lane
  import pp_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  pk_mode_e                  mode,
  input  logic [SMP_W-1:0]          y,
  input  logic [SMP_W-1:0]          c,
  input  logic                      xpar,
  input  logic                      lpar,
  output logic [2*SMP_W-1:0]        chunk,
  output logic [$clog2(SMP_W/4):0]  nbytes,
  output logic                      ckeep,
  output logic [SMP_W-1:0]          csmp
);
  localparam int H    = SMP_W / 2;
  localparam int NB_W = $clog2(SMP_W/4) + 1;

  // Per-pixel contribution to the main word stream (low bits = earlier bytes)
  always_comb begin
    case (mode)
      PK_YC8: begin
        chunk  = {{SMP_W{1'b0}}, c[H-1:0], y[H-1:0]};
        nbytes = NB_W'(2);
      end
      PK_CY16: begin
        chunk  = {y, c};
        nbytes = NB_W'(4);
      end
      PK_YC16: begin
        chunk  = {c, y};
        nbytes = NB_W'(4);
      end
      PK_MB8: begin
        chunk  = {{(SMP_W+H){1'b0}}, y[H-1:0]};
        nbytes = NB_W'(1);
      end
      PK_MB16: begin
        chunk  = {{SMP_W{1'b0}}, y};
        nbytes = NB_W'(2);
      end
      default: begin
        chunk  = {{SMP_W{1'b0}}, y[H-1:0], c[H-1:0]};
        nbytes = NB_W'(2);
      end
    endcase
  end

  // 4:2:0 chroma: keep samples whose pixel parity matches the line parity
  always_comb begin
    ckeep = mode_is_mb(mode) && (xpar == lpar);
    csmp  = mode_is_wide(mode) ? c : {{H{1'b0}}, c[H-1:0]};
  end

endmodule

// File: rtl/pp_desc.sv
module pp_desc
  import pp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_wr,
  input  pk_mode_e          q_mode,
  input  logic [ADDR_W-1:0] q_base,
  input  logic              post,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic              busy,
  input  logic              fin,
  input  logic              irq_clr,
  output logic              start,
  output pk_mode_e          act_mode,
  output logic [ADDR_W-1:0] act_base,
  output logic              irq
);
  pk_mode_e          mode_q;
  logic [ADDR_W-1:0] base_q;
  logic              armed_q, armed_n;
  logic              irq_q, irq_n;

  always_comb begin
    start   = armed_q && !busy && pix_valid && pix_sof;
    armed_n = armed_q;
    if (start) armed_n = 1'b0;
    if (post)  armed_n = 1'b1;
    if (q_wr)  armed_n = 1'b0;
    irq_n    = fin | (irq_q & ~irq_clr);
    act_mode = mode_q;
    act_base = base_q;
    irq      = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PK_CY8;
      base_q  <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (q_wr) begin
        mode_q <= q_mode;
        base_q <= q_base;
      end
      armed_q <= armed_n;
      irq_q   <= irq_n;
    end
  end

endmodule

// File: rtl/pp_pack.sv
module pp_pack
  import pp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64,
  parameter int SMP_W  = 16,
  parameter int GRP    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pk_mode_e          st_mode,
  input  logic [ADDR_W-1:0] st_base,
  input  logic              pix_valid,
  input  logic              pix_eol,
  input  logic              pix_eof,
  input  logic [SMP_W-1:0]  pix_y,
  input  logic [SMP_W-1:0]  pix_c,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              fin
);
  localparam int WORD_B = WORD_W / 8;
  localparam int PTR_W  = $clog2(WORD_B);
  localparam int CH_W   = 2 * SMP_W;
  localparam int NB_W   = $clog2(SMP_W/4) + 1;
  localparam int CACC_W = (GRP / 2) * SMP_W;
  localparam int CSH_W  = $clog2(CACC_W);
  localparam int CI_W   = $clog2(GRP / 2);
  localparam int GI_W   = $clog2(GRP);
  localparam int DW_N   = CACC_W / WORD_W;
  localparam int DC_W   = $clog2(DW_N + 1);

  // registers
  logic              act_q, act_n;
  pk_mode_e          mode_q;
  logic              xpar_q, xpar_n, lpar_q, lpar_n;
  logic [GI_W-1:0]   grp_q, grp_n;
  logic [WORD_W-1:0] acc_q, acc_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic [CACC_W-1:0] cacc_q, cacc_n;
  logic [CI_W-1:0]   cidx_q, cidx_n;
  logic [CACC_W-1:0] drn_q, drn_n;
  logic [DC_W-1:0]   dcnt_q, dcnt_n;
  logic              dlast_q, dlast_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              ov_q, ov_n;
  logic [WORD_W-1:0] od_q, od_n;
  logic [ADDR_W-1:0] oa_q, oa_n;

  // effective current state (start re-initialises the frame context)
  pk_mode_e          eff_mode;
  logic              xpar_c, lpar_c;
  logic [GI_W-1:0]   grp_c;
  logic [WORD_W-1:0] acc_c;
  logic [PTR_W-1:0]  ptr_c;
  logic [CACC_W-1:0] cacc_c;
  logic [CI_W-1:0]   cidx_c;
  logic [ADDR_W-1:0] addr_c;

  logic [CH_W-1:0]   chunk;
  logic [NB_W-1:0]   nbytes;
  logic              ckeep;
  logic [SMP_W-1:0]  csmp;

  logic              mb, wide, take, emit_m, emit_d, gend, cadv;
  logic [PTR_W:0]    nptr;
  logic [WORD_W-1:0] acc_ins;
  logic [CACC_W-1:0] cacc_ins;
  logic [CSH_W-1:0]  csh;
  logic              en_act, en_pix, en_drn, en_addr, en_out;

  pp_lane #(.SMP_W(SMP_W)) u_lane (
    .mode   (eff_mode),
    .y      (pix_y),
    .c      (pix_c),
    .xpar   (xpar_c),
    .lpar   (lpar_c),
    .chunk  (chunk),
    .nbytes (nbytes),
    .ckeep  (ckeep),
    .csmp   (csmp)
  );

  always_comb begin
    eff_mode = start ? st_mode : mode_q;
    xpar_c   = start ? 1'b0 : xpar_q;
    lpar_c   = start ? 1'b0 : lpar_q;
    grp_c    = start ? '0   : grp_q;
    acc_c    = start ? '0   : acc_q;
    ptr_c    = start ? '0   : ptr_q;
    cacc_c   = start ? '0   : cacc_q;
    cidx_c   = start ? '0   : cidx_q;
    addr_c   = start ? st_base : addr_q;

    mb   = mode_is_mb(eff_mode);
    wide = mode_is_wide(eff_mode);
    take = (act_q || start) && pix_valid;

    // main word accumulation
    acc_ins = acc_c | ({{(WORD_W-CH_W){1'b0}}, chunk} << {ptr_c, 3'b000});
    nptr    = {1'b0, ptr_c} + (PTR_W+1)'(nbytes);
    emit_m  = take && ((nptr == (PTR_W+1)'(WORD_B)) || pix_eof);

    // 4:2:0 chroma accumulation
    csh      = wide ? CSH_W'(cidx_c) * CSH_W'(SMP_W) : CSH_W'(cidx_c) * CSH_W'(8);
    cadv     = take && mb && ckeep;
    cacc_ins = cadv ? (cacc_c | (CACC_W'(csmp) << csh)) : cacc_c;
    gend     = take && mb && (grp_c == GI_W'(GRP - 1));

    emit_d = !emit_m && (dcnt_q != '0);
    fin    = (emit_d && (dcnt_q == DC_W'(1)) && dlast_q) ||
             (emit_m && pix_eof && !gend);
    busy   = act_q || (dcnt_q != '0);

    // next state
    en_act = start || (take && pix_eof);
    act_n  = !(take && pix_eof);

    en_pix = take;
    if (pix_eol) begin
      xpar_n = 1'b0;
      lpar_n = ~lpar_c;
      grp_n  = '0;
    end else begin
      xpar_n = ~xpar_c;
      lpar_n = lpar_c;
      grp_n  = grp_c + GI_W'(1);
    end
    acc_n  = emit_m ? '0 : acc_ins;
    ptr_n  = emit_m ? '0 : nptr[PTR_W-1:0];
    cacc_n = gend ? '0 : cacc_ins;
    cidx_n = gend ? '0 : cidx_c + CI_W'(cadv);

    en_drn = gend || emit_d;
    if (gend) begin
      drn_n   = cacc_ins;
      dcnt_n  = wide ? DC_W'(DW_N) : DC_W'(1);
      dlast_n = pix_eof;
    end else begin
      drn_n   = drn_q >> WORD_W;
      dcnt_n  = dcnt_q - DC_W'(1);
      dlast_n = dlast_q;
    end

    en_out  = emit_m || emit_d;
    en_addr = start || en_out;
    addr_n  = addr_c + ADDR_W'(en_out);
    ov_n    = en_out;
    od_n    = emit_m ? acc_ins : drn_q[WORD_W-1:0];
    oa_n    = addr_c;

    wr_valid = ov_q;
    wr_data  = od_q;
    wr_addr  = oa_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      mode_q  <= PK_CY8;
      xpar_q  <= 1'b0;
      lpar_q  <= 1'b0;
      grp_q   <= '0;
      acc_q   <= '0;
      ptr_q   <= '0;
      cacc_q  <= '0;
      cidx_q  <= '0;
      drn_q   <= '0;
      dcnt_q  <= '0;
      dlast_q <= 1'b0;
      addr_q  <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
      oa_q    <= '0;
    end else begin
      if (en_act) act_q  <= act_n;
      if (start)  mode_q <= st_mode;
      if (en_pix) begin
        xpar_q <= xpar_n;
        lpar_q <= lpar_n;
        grp_q  <= grp_n;
        acc_q  <= acc_n;
        ptr_q  <= ptr_n;
        cacc_q <= cacc_n;
        cidx_q <= cidx_n;
      end
      if (en_drn) begin
        drn_q   <= drn_n;
        dcnt_q  <= dcnt_n;
        dlast_q <= dlast_n;
      end
      if (en_addr) addr_q <= addr_n;
      ov_q <= ov_n;
      if (en_out) begin
        od_q <= od_n;
        oa_q <= oa_n;
      end
    end
  end

endmodule

// File: rtl/pix_pack_wr.sv
module pix_pack_wr
  import pp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 64,
  parameter int SMP_W  = 16,
  parameter int GRP    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsc_queue,
  input  logic [2:0]        dsc_mode,
  input  logic [ADDR_W-1:0] dsc_base,
  input  logic              dsc_post,
  input  logic              irq_clr,
  input  logic              pix_valid,
  input  logic              pix_sof,
  input  logic              pix_eol,
  input  logic              pix_eof,
  input  logic [SMP_W-1:0]  pix_y,
  input  logic [SMP_W-1:0]  pix_c,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              irq
);
  // reset asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic              start_w, busy_w, fin_w;
  pk_mode_e          act_mode_w;
  logic [ADDR_W-1:0] act_base_w;

  pp_desc #(.ADDR_W(ADDR_W)) u_desc (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .q_wr      (dsc_queue),
    .q_mode    (pk_mode_e'(dsc_mode)),
    .q_base    (dsc_base),
    .post      (dsc_post),
    .pix_valid (pix_valid),
    .pix_sof   (pix_sof),
    .busy      (busy_w),
    .fin       (fin_w),
    .irq_clr   (irq_clr),
    .start     (start_w),
    .act_mode  (act_mode_w),
    .act_base  (act_base_w),
    .irq       (irq)
  );

  pp_pack #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .SMP_W  (SMP_W),
    .GRP    (GRP)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start_w),
    .st_mode   (act_mode_w),
    .st_base   (act_base_w),
    .pix_valid (pix_valid),
    .pix_eol   (pix_eol),
    .pix_eof   (pix_eof),
    .pix_y     (pix_y),
    .pix_c     (pix_c),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_addr   (wr_addr),
    .busy      (busy_w),
    .fin       (fin_w)
  );

endmodule

// File: rtl/pp_chk.sv
module pp_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              irq_clr,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              start,
  input logic              busy,
  input logic              pix_eof,
  input logic [ADDR_W-1:0] st_base
);
  logic [ADDR_W-1:0] exp_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        exp_a <= '0;
    else if (start)    exp_a <= st_base;
    else if (wr_valid) exp_a <= wr_addr + ADDR_W'(1);
  end

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> wr_valid);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !pix_eof |=> busy);

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr == exp_a);

endmodule

bind pix_pack_wr pp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .irq_clr  (irq_clr),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .start    (start_w),
  .busy     (busy_w),
  .pix_eof  (pix_eof),
  .st_base  (act_base_w)
);

// File: tb/tb_pix_pack_wr.sv
`timescale 1ns/1ps
module tb_pix_pack_wr;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dsc_queue, dsc_post, irq_clr;
  logic [2:0]  dsc_mode;
  logic [31:0] dsc_base;
  logic        pix_valid, pix_sof, pix_eol, pix_eof;
  logic [15:0] pix_y, pix_c;
  logic        wr_valid, irq;
  logic [63:0] wr_data;
  logic [31:0] wr_addr;

  always #2 clk = ~clk;

  pix_pack_wr dut (
    .clk(clk), .rst_n(rst_n), .dsc_queue(dsc_queue), .dsc_mode(dsc_mode),
    .dsc_base(dsc_base), .dsc_post(dsc_post), .irq_clr(irq_clr),
    .pix_valid(pix_valid), .pix_sof(pix_sof), .pix_eol(pix_eol),
    .pix_eof(pix_eof), .pix_y(pix_y), .pix_c(pix_c),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr(wr_addr), .irq(irq)
  );

  int n_chk = 0, n_err = 0, bc = 0;
  bit done = 0, m_irq = 0;
  logic [63:0] eq_d[$];
  logic [31:0] eq_a[$];
  bit          eq_l[$];
  string       eq_t[$];

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] py(int s, int l, int x);
    return 16'(s * 4099 + l * 257 + x * 13 + 'hA500);
  endfunction
  function automatic logic [15:0] pc(int s, int l, int x);
    return 16'(s * 7919 + l * 31 + x * 97 + 'h3C05);
  endfunction

  // behavioural byte-stream model of one captured frame
  task automatic expect_frame(int mode, int base, int w, int h, int s, string tag);
    logic [7:0] bq[$];
    for (int l = 0; l < h; l++) begin
      if (mode < 4) begin
        for (int x = 0; x < w; x++) begin
          logic [15:0] y, c;
          y = py(s, l, x); c = pc(s, l, x);
          case (mode)
            0: begin bq.push_back(c[7:0]); bq.push_back(y[7:0]); end
            1: begin bq.push_back(y[7:0]); bq.push_back(c[7:0]); end
            2: begin bq.push_back(c[7:0]); bq.push_back(c[15:8]);
                     bq.push_back(y[7:0]); bq.push_back(y[15:8]); end
            default: begin bq.push_back(y[7:0]); bq.push_back(y[15:8]);
                     bq.push_back(c[7:0]); bq.push_back(c[15:8]); end
          endcase
        end
      end else begin
        for (int g = 0; g < w / 16; g++) begin
          for (int k = 0; k < 16; k++) begin
            logic [15:0] y;
            y = py(s, l, g * 16 + k);
            bq.push_back(y[7:0]);
            if (mode == 5) bq.push_back(y[15:8]);
          end
          for (int k = 0; k < 16; k++) begin
            if ((k % 2) == (l % 2)) begin
              logic [15:0] c;
              c = pc(s, l, g * 16 + k);
              bq.push_back(c[7:0]);
              if (mode == 5) bq.push_back(c[15:8]);
            end
          end
        end
      end
    end
    begin
      int nw;
      nw = (bq.size() + 7) / 8;
      for (int i = 0; i < nw; i++) begin
        logic [63:0] wd;
        wd = '0;
        for (int b = 0; b < 8; b++)
          if (i * 8 + b < bq.size()) wd[b*8 +: 8] = bq[i * 8 + b];
        eq_d.push_back(wd);
        eq_a.push_back(32'(base + i));
        eq_l.push_back(i == nw - 1);
        eq_t.push_back(tag);
      end
    end
  endtask

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_valid) begin
        bc++;
        if (eq_d.size() == 0) begin
          chk(0, "R1 unexpected beat", wr_data, 64'h0);
        end else begin
          logic [63:0] ed; logic [31:0] ea; bit el; string et;
          ed = eq_d.pop_front(); ea = eq_a.pop_front();
          el = eq_l.pop_front(); et = eq_t.pop_front();
          chk(wr_data == ed, {et, " data"}, wr_data, ed);
          chk(wr_addr == ea, "R9 address", 64'(wr_addr), 64'(ea));
          if (el) m_irq = 1;
        end
      end
      chk(irq == m_irq, "R10 irq", 64'(irq), 64'(m_irq));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic queue_dsc(int mode, int base);
    @(negedge clk);
    dsc_queue = 1; dsc_mode = 3'(mode); dsc_base = 32'(base);
    @(negedge clk);
    dsc_queue = 0;
  endtask

  task automatic post_dsc();
    @(negedge clk); dsc_post = 1;
    @(negedge clk); dsc_post = 0;
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1;
    @(posedge clk); #1 m_irq = 0;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic drive_frame(int w, int h, int s, bit gap);
    for (int l = 0; l < h; l++) begin
      for (int x = 0; x < w; x++) begin
        @(negedge clk);
        pix_valid = 1;
        pix_sof = (l == 0 && x == 0);
        pix_eol = (x == w - 1);
        pix_eof = (l == h - 1 && x == w - 1);
        pix_y = py(s, l, x); pix_c = pc(s, l, x);
        if (gap && (x % 3 == 1)) begin
          @(negedge clk);
          pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_eof = 0;
          pix_y = 16'hFFFF; pix_c = 16'hFFFF;
        end
      end
    end
    @(negedge clk);
    pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_eof = 0;
  endtask

  task automatic run_frame(int mode, int base, int w, int h, int s, bit gap, string tag);
    queue_dsc(mode, base);
    post_dsc();
    expect_frame(mode, base, w, h, s, tag);
    drive_frame(w, h, s, gap);
    idle(8);
    chk(irq == 1, {tag, " R10 irq after frame"}, 64'(irq), 64'h1);
    chk(eq_d.size() == 0, {tag, " all words seen"}, 64'(eq_d.size()), 64'h0);
    clr_irq();
    chk(irq == 0, "R10 irq cleared", 64'(irq), 64'h0);
  endtask

  initial begin
    rst_n = 0; dsc_queue = 0; dsc_post = 0; irq_clr = 0;
    dsc_mode = 0; dsc_base = 0;
    pix_valid = 0; pix_sof = 0; pix_eol = 0; pix_eof = 0;
    pix_y = 0; pix_c = 0;
    idle(5);
    chk(wr_valid == 0, "R9 reset beat", 64'(wr_valid), 64'h0);
    chk(irq == 0, "R10 reset irq", 64'(irq), 64'h0);
    rst_n = 1;
    idle(5);

    begin : t_r1
      int b0;
      b0 = bc;
      queue_dsc(0, 'h100);
      drive_frame(4, 2, 1, 0);
      idle(6);
      chk(bc == b0, "R1 queued only", 64'(bc), 64'(b0));
      post_dsc();
      queue_dsc(0, 'h140);
      drive_frame(4, 2, 2, 0);
      idle(6);
      chk(bc == b0, "R1 requeue disarms", 64'(bc), 64'(b0));
      chk(irq == 0, "R1 no irq", 64'(irq), 64'h0);
    end

    begin : t_r2
      int b0;
      b0 = bc;
      queue_dsc(0, 'h300);
      fork
        drive_frame(4, 3, 20, 0);
        begin idle(4); post_dsc(); end
      join
      idle(6);
      chk(bc == b0, "R2 mid-frame skipped", 64'(bc), 64'(b0));
      expect_frame(0, 'h300, 4, 2, 21, "R2");
      drive_frame(4, 2, 21, 0);
      idle(8);
      chk(eq_d.size() == 0, "R2 next frame captured", 64'(eq_d.size()), 64'h0);
      idle(20);
      chk(irq == 1, "R10 irq sticky", 64'(irq), 64'h1);
      clr_irq();
    end

    run_frame(0, 'h1000, 6, 2, 3, 0, "R3,R7");
    run_frame(1, 'h2000, 4, 3, 4, 1, "R4,R11");
    run_frame(2, 'h3000, 3, 2, 5, 0, "R5");
    run_frame(3, 'h4000, 5, 1, 6, 0, "R5,R8");
    run_frame(0, 'h5000, 5, 1, 7, 1, "R8");
    run_frame(4, 'h6000, 32, 2, 8, 0, "R6,R7");
    run_frame(5, 'h7000, 16, 3, 9, 1, "R6");
    run_frame(5, 'hFFFFFFFE, 32, 2, 10, 0, "R9,R6");

    idle(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

endmodule